// File: doc/BRIEF.md
# Write-Protected System Clock Control Register

This block holds the eight-bit control word of a small clock unit. Software writes it over a plain address, data and strobe interface. Every write is gated by a protect-enable input. A separate clock-change lock input freezes the bits that switch clock sources. The block decodes the word into control fields:

- selection of the function on the clock-output pin;
- peripheral clock stop during wait;
- sub-oscillator drive strength and enable;
- main-oscillator stop;
- watchdog action;
- CPU clock source.

The block also owns a companion five-bit clock-divider register. That register has its own write port. Hardware forces it to divide-by-8 whenever software stops the main oscillator, unless the on-chip oscillator mode is active. A stop-mode entry pulse raises the sub-oscillator drive bit. A four-way selector drives the clock-output pin from the port data, fC, f8 or f32.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the control word reads 0x08, the divider reads 0x08 and the sequence error flag is 0.
- R2: A control write (wr_en_i=1 with addr_i equal to CTRL_ADDR) is applied only when protect_en_i is 1. Any other write, including one to another address, leaves the word unchanged.
- R3: Bits 1:0 select the pin function: 00 gives port data if port_en_i=1 and 0 otherwise, 01 gives clk_fc_i, 10 gives clk_f8_i, 11 gives clk_f32_i.
- R4: Bit 6 (watchdog action, 1 gives reset) can be set by a write. It cannot be cleared by a write. Only reset clears it.
- R5: While clk_lock_i is 1, writes leave bits 2, 5 and 7 unchanged. Bits 0, 1, 3, 4 and 6 still follow the write.
- R6: An applied write that puts 1 in bit 5 loads 01000b into the divider on the same edge, unless onchip_mode_i is 1. This load has priority over a divider write in the same cycle.
- R7: A stop_entry_i pulse sets bit 3 on the next edge, with priority over a write in the same cycle.
- R8: An unlocked applied write that would change bit 7 while it also changes bit 4 or bit 5 keeps the old bit 7. The write still updates the other bits, and it sets seq_err_o, which stays 1 until reset.
- R9: rdata_o always shows the current control word, whatever protect_en_i is.
- R10: div_wr_i=1 loads div_wdata_i into the divider on the next edge when no forced load applies.
- R11: Outputs map to bits as follows: bit 2 to per_stop_wait_o, bit 3 to sub_drive_o, bit 4 to sub_osc_en_o, bit 5 to main_stop_o, bit 6 to wdt_reset_o, bit 7 to cpu_sub_sel_o, bits 1:0 to clkout_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Bus write address |
| wdata_i | input | 8 | Bus write data |
| protect_en_i | input | 1 | Write protection released when 1 |
| clk_lock_i | input | 1 | Freezes clock-switch bits 2, 5, 7 |
| onchip_mode_i | input | 1 | On-chip oscillator mode, blocks the divider force |
| stop_entry_i | input | 1 | Stop-mode entry pulse |
| div_wr_i | input | 1 | Divider write strobe |
| div_wdata_i | input | DIV_W | Divider write data |
| port_en_i | input | 1 | Port function enabled on the clock pin |
| port_d_i | input | 1 | Port data for the clock pin |
| clk_fc_i | input | 1 | fC source |
| clk_f8_i | input | 1 | f8 source |
| clk_f32_i | input | 1 | f32 source |
| rdata_o | output | 8 | Current control word |
| div_o | output | DIV_W | Divider register |
| seq_err_o | output | 1 | Sticky clock-switch sequence error |
| clkout_sel_o | output | 2 | Clock pin select field |
| per_stop_wait_o | output | 1 | Peripheral clock stops in wait |
| sub_drive_o | output | 1 | Sub-oscillator drive high |
| sub_osc_en_o | output | 1 | Sub-oscillator enabled |
| main_stop_o | output | 1 | Main oscillator stopped |
| wdt_reset_o | output | 1 | Watchdog causes reset |
| cpu_sub_sel_o | output | 1 | CPU runs from sub clock |
| clk_pin_o | output | 1 | Clock-output pin |

## Verification
A wrong bit in the control word shows on rdata_o and on its decoded output on the edge right after the write or the stop pulse. A wrong select field shows on clk_pin_o in the same cycle, while the bench toggles the pin sources. A missed or wrongly ranked divider load shows on div_o one edge after the write that stops the main clock. A dropped sticky flag or a cleared watchdog bit stays visible from then on, so the per-cycle comparison against the bench model catches it on the first cycle after it happens.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic [REG_W-1:0] CTRL_RST = 8'h08;

  typedef enum logic [1:0] {
    PIN_PORT = 2'b00,
    PIN_FC   = 2'b01,
    PIN_F8   = 2'b10,
    PIN_F32  = 2'b11
  } pin_sel_e;

  // field order matches bit 7 down to bit 0
  typedef struct packed {
    logic       cpu_sub;
    logic       wdt_rst;
    logic       main_stop;
    logic       sub_en;
    logic       sub_drv;
    logic       per_stop;
    logic [1:0] pin_sel;
  } ctrl_t;
endpackage

// File: rtl/sysclk_ctrl_core.sv
module sysclk_ctrl_core
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hit_i,
  input  logic             protect_en_i,
  input  logic             clk_lock_i,
  input  logic             stop_entry_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output logic             seq_err_o,
  output logic             mstop_set_o
);
  ctrl_t cur_q, nxt_d, w;
  logic  err_q, err_d;
  logic  wr_ok, clash;

  assign w     = ctrl_t'(wdata_i);
  assign wr_ok = wr_hit_i & protect_en_i;
  // source switch must not move together with an oscillator enable/stop
  assign clash = !clk_lock_i && (w.cpu_sub != cur_q.cpu_sub) &&
                 ((w.sub_en != cur_q.sub_en) || (w.main_stop != cur_q.main_stop));

  always_comb begin
    nxt_d = cur_q;
    err_d = err_q;
    if (wr_ok) begin
      nxt_d.pin_sel = w.pin_sel;
      nxt_d.sub_drv = w.sub_drv;
      nxt_d.sub_en  = w.sub_en;
      nxt_d.wdt_rst = cur_q.wdt_rst | w.wdt_rst;
      if (!clk_lock_i) begin
        nxt_d.per_stop  = w.per_stop;
        nxt_d.main_stop = w.main_stop;
        if (!clash) nxt_d.cpu_sub = w.cpu_sub;
      end
      if (clash) err_d = 1'b1;
    end
    if (stop_entry_i) nxt_d.sub_drv = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= ctrl_t'(CTRL_RST);
      err_q <= 1'b0;
    end else begin
      cur_q <= nxt_d;
      err_q <= err_d;
    end
  end

  assign ctrl_o      = cur_q;
  assign seq_err_o   = err_q;
  assign mstop_set_o = wr_ok & ~clk_lock_i & w.main_stop;
endmodule

// File: rtl/sysclk_div_reg.sv
module sysclk_div_reg #(
  parameter int unsigned       DIV_W     = 5,
  parameter logic [DIV_W-1:0]  DIV_RST   = DIV_W'(8),
  parameter logic [DIV_W-1:0]  DIV_FORCE = DIV_W'(8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             force_i,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] wdata_i,
  output logic [DIV_W-1:0] div_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= DIV_RST;
    else if (force_i) div_q <= DIV_FORCE;
    else if (wr_i)    div_q <= wdata_i;
  end

  assign div_o = div_q;
endmodule

// File: rtl/sysclk_pin_mux.sv
module sysclk_pin_mux
  import sysclk_pkg::*;
(
  input  pin_sel_e sel_i,
  input  logic     port_en_i,
  input  logic     port_d_i,
  input  logic     fc_i,
  input  logic     f8_i,
  input  logic     f32_i,
  output logic     pin_o
);
  always_comb begin
    unique case (sel_i)
      PIN_FC:  pin_o = fc_i;
      PIN_F8:  pin_o = f8_i;
      PIN_F32: pin_o = f32_i;
      default: pin_o = port_en_i & port_d_i;
    endcase
  end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]        CTRL_ADDR = ADDR_W'(6),
  parameter int unsigned              DIV_W     = 5,
  parameter logic [DIV_W-1:0]         DIV_RST   = DIV_W'(8),
  parameter logic [DIV_W-1:0]         DIV_FORCE = DIV_W'(8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              protect_en_i,
  input  logic              clk_lock_i,
  input  logic              onchip_mode_i,
  input  logic              stop_entry_i,
  input  logic              div_wr_i,
  input  logic [DIV_W-1:0]  div_wdata_i,
  input  logic              port_en_i,
  input  logic              port_d_i,
  input  logic              clk_fc_i,
  input  logic              clk_f8_i,
  input  logic              clk_f32_i,
  output logic [7:0]        rdata_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              seq_err_o,
  output logic [1:0]        clkout_sel_o,
  output logic              per_stop_wait_o,
  output logic              sub_drive_o,
  output logic              sub_osc_en_o,
  output logic              main_stop_o,
  output logic              wdt_reset_o,
  output logic              cpu_sub_sel_o,
  output logic              clk_pin_o
);
  ctrl_t ctrl;
  logic  wr_hit, mstop_set, div_force;

  assign wr_hit    = wr_en_i && (addr_i == CTRL_ADDR);
  assign div_force = mstop_set & ~onchip_mode_i;

  sysclk_ctrl_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_hit_i     (wr_hit),
    .protect_en_i (protect_en_i),
    .clk_lock_i   (clk_lock_i),
    .stop_entry_i (stop_entry_i),
    .wdata_i      (wdata_i),
    .ctrl_o       (ctrl),
    .seq_err_o    (seq_err_o),
    .mstop_set_o  (mstop_set)
  );

  sysclk_div_reg #(
    .DIV_W     (DIV_W),
    .DIV_RST   (DIV_RST),
    .DIV_FORCE (DIV_FORCE)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (div_force),
    .wr_i    (div_wr_i),
    .wdata_i (div_wdata_i),
    .div_o   (div_o)
  );

  sysclk_pin_mux u_mux (
    .sel_i     (pin_sel_e'(ctrl.pin_sel)),
    .port_en_i (port_en_i),
    .port_d_i  (port_d_i),
    .fc_i      (clk_fc_i),
    .f8_i      (clk_f8_i),
    .f32_i     (clk_f32_i),
    .pin_o     (clk_pin_o)
  );

  assign rdata_o         = ctrl;
  assign clkout_sel_o    = ctrl.pin_sel;
  assign per_stop_wait_o = ctrl.per_stop;
  assign sub_drive_o     = ctrl.sub_drv;
  assign sub_osc_en_o    = ctrl.sub_en;
  assign main_stop_o     = ctrl.main_stop;
  assign wdt_reset_o     = ctrl.wdt_rst;
  assign cpu_sub_sel_o   = ctrl.cpu_sub;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(6),
  parameter int unsigned       DIV_W     = 5,
  parameter logic [DIV_W-1:0]  DIV_FORCE = DIV_W'(8)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              protect_en_i,
  input logic              clk_lock_i,
  input logic              onchip_mode_i,
  input logic              stop_entry_i,
  input logic              clk_fc_i,
  input logic              clk_f8_i,
  input logic              clk_f32_i,
  input logic [7:0]        rdata_o,
  input logic [DIV_W-1:0]  div_o,
  input logic              seq_err_o,
  input logic [1:0]        clkout_sel_o,
  input logic              sub_drive_o,
  input logic              wdt_reset_o,
  input logic              clk_pin_o
);
  logic applied;
  assign applied = wr_en_i && (addr_i == CTRL_ADDR) && protect_en_i;

  p_protect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!applied && !stop_entry_i) |=> $stable(rdata_o));

  p_pin_fc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clkout_sel_o == 2'b01) |-> (clk_pin_o == clk_fc_i));

  p_pin_f8_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clkout_sel_o == 2'b10) |-> (clk_pin_o == clk_f8_i));

  p_pin_f32_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clkout_sel_o == 2'b11) |-> (clk_pin_o == clk_f32_i));

  p_wdt_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_reset_o |=> wdt_reset_o);

  p_lock_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_lock_i |=> $stable({rdata_o[7], rdata_o[5], rdata_o[2]}));

  p_div_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (applied && wdata_i[5] && !clk_lock_i && !onchip_mode_i) |=> (div_o == DIV_FORCE));

  p_stop_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_entry_i |=> sub_drive_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o);
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .CTRL_ADDR (CTRL_ADDR),
  .DIV_W     (DIV_W),
  .DIV_FORCE (DIV_FORCE)
) u_chk (.*);

// File: tb/sysclk_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysclk_ctrl_tb_top;
  localparam int AW = 4;
  localparam logic [AW-1:0] CA = 4'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, prot = 0, lock = 0, onchip = 0, stop = 0, div_wr = 0;
  logic port_en = 0, port_d = 0, fc = 0, f8 = 0, f32 = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [4:0] div_wd = '0;
  logic [7:0] rdata;
  logic [4:0] div;
  logic seq_err, pstop, sdrv, sen, mstop, wdt, cpus, pin;
  logic [1:0] sel;

  int vectors = 0, errors = 0;
  logic [7:0] m_reg;
  logic [4:0] m_div;
  logic m_err;

  always #5 clk = ~clk;

  sysclk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .protect_en_i(prot), .clk_lock_i(lock), .onchip_mode_i(onchip), .stop_entry_i(stop),
    .div_wr_i(div_wr), .div_wdata_i(div_wd), .port_en_i(port_en), .port_d_i(port_d),
    .clk_fc_i(fc), .clk_f8_i(f8), .clk_f32_i(f32), .rdata_o(rdata), .div_o(div),
    .seq_err_o(seq_err), .clkout_sel_o(sel), .per_stop_wait_o(pstop), .sub_drive_o(sdrv),
    .sub_osc_en_o(sen), .main_stop_o(mstop), .wdt_reset_o(wdt), .cpu_sub_sel_o(cpus),
    .clk_pin_o(pin)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 8'h08; m_div = 5'd8; m_err = 1'b0;
    end else begin
      logic [7:0] nr;
      logic clash, frc;
      nr = m_reg; frc = 1'b0;
      if (wr_en && addr == CA && prot) begin
        clash = !lock && (wdata[7] != m_reg[7]) &&
                ((wdata[4] != m_reg[4]) || (wdata[5] != m_reg[5]));
        nr[0] = wdata[0]; nr[1] = wdata[1]; nr[3] = wdata[3]; nr[4] = wdata[4];
        nr[6] = m_reg[6] | wdata[6];
        if (!lock) begin
          nr[2] = wdata[2]; nr[5] = wdata[5];
          if (!clash) nr[7] = wdata[7];
          frc = wdata[5] && !onchip;
        end
        if (clash) m_err = 1'b1;
      end
      if (stop) nr[3] = 1'b1;
      m_reg = nr;
      if (frc) m_div = 5'd8;
      else if (div_wr) m_div = div_wd;
    end
  end

  function automatic logic exp_pin();
    case (m_reg[1:0])
      2'b01:   return fc;
      2'b10:   return f8;
      2'b11:   return f32;
      default: return port_en & port_d;
    endcase
  endfunction

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    cmp("R9 rdata", rdata, m_reg);
    cmp("R6/R10 div", div, m_div);
    cmp("R8 seq_err", seq_err, m_err);
    cmp("R3 pin", pin, exp_pin());
    cmp("R11 fields", {cpus, wdt, mstop, sen, sdrv, pstop, sel}, m_reg);
  endtask

  // compare away from the rising edge, then apply the next stimulus
  task automatic step(logic w, logic [AW-1:0] a, logic [7:0] d, logic p);
    @(negedge clk);
    compare();
    wr_en = w; addr = a; wdata = d; prot = p;
    fc = ~fc; if (vectors % 2 == 0) f8 = ~f8; if (vectors % 4 == 0) f32 = ~f32;
  endtask

  task automatic wr(logic [7:0] d); step(1'b1, CA, d, 1'b1); endtask
  task automatic idle(); step(1'b0, CA, 8'h00, 1'b0); endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    idle(); idle();
    // R2 protect gating and address mismatch
    step(1'b1, CA, 8'hFF, 1'b0); idle();
    step(1'b1, 4'd3, 8'h03, 1'b1); idle();
    // R3 select field with port on/off, R9 reads while protected
    port_en = 1'b0; port_d = 1'b1;
    wr(8'h00); idle(); port_en = 1'b1; idle(); port_d = 1'b0; idle();
    wr(8'h01); idle(); idle(); wr(8'h02); idle(); idle(); wr(8'h03); idle(); idle();
    // R11 field map
    wr(8'h1C); idle(); wr(8'h24); idle(); wr(8'h00); idle();
    // R4 watchdog bit sticky
    wr(8'h40); idle(); wr(8'h00); idle(); wr(8'h3F); idle();
    // R5 lock
    wr(8'h00); idle();
    lock = 1'b1; wr(8'hA7); idle(); wr(8'h1B); idle(); lock = 1'b0;
    // R10 divider port, R6 forced load rules
    div_wr = 1'b1; div_wd = 5'd3; idle(); div_wr = 1'b0; idle();
    onchip = 1'b1; wr(8'h20); idle(); onchip = 1'b0;
    wr(8'h00); idle();
    div_wr = 1'b1; div_wd = 5'd5; wr(8'h20); div_wr = 1'b0; idle();
    lock = 1'b1; div_wr = 1'b1; div_wd = 5'd2; wr(8'h20); div_wr = 1'b0; idle(); lock = 1'b0;
    // R7 stop entry over a write clearing bit 3
    wr(8'h00); idle(); stop = 1'b1; wr(8'h00); stop = 1'b0; idle();
    // R8 source change together with oscillator bits
    wr(8'h00); idle(); wr(8'h90); idle(); wr(8'h00); idle(); wr(8'h80); idle(); wr(8'hA0); idle();
    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      lock = ($urandom % 4) == 0; onchip = ($urandom % 3) == 0; stop = ($urandom % 8) == 0;
      div_wr = ($urandom % 4) == 0; div_wd = 5'($urandom);
      port_en = 1'($urandom); port_d = 1'($urandom);
      step(1'($urandom), (($urandom % 3) == 0) ? 4'($urandom) : CA, 8'($urandom), ($urandom % 4) != 0);
    end
    stop = 0; div_wr = 0; lock = 0;
    idle(); idle();
    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule